// File: doc/BRIEF.md
# Digital Seconds-Rate Trim for a Real-Time Clock Divider

This block sits in the prescaler that turns a 32.768 kHz oscillator tick into the one-per-second tick of a real-time clock. It trims the clock's rate digitally. In selected seconds it shortens the count, so the clock gains time, or it lengthens the count, so the clock loses time. The oscillator itself is left alone. A 64-minute cycle sets where the adjustments go. A step count N adjusts one second, the first of its minute, in each of the first 2×N minutes. The cap is 62 adjusted minutes per cycle.

The trim setting is a 5-bit step count and a direction bit. These are plain control inputs. The block samples them at the start of each 64-minute cycle, so a change that arrives mid-cycle takes effect only when the next cycle begins.

The block also produces a 512 Hz square wave for checking the clock's rate. It divides the raw oscillator tick, ahead of any trim, and shows it on a test pin while the test pin is enabled. There is no streaming data path, so every pin is a plain level or a single-cycle pulse and no valid/ready handshake is needed. All parameters are given as defaults and can be scaled down for simulation.

Top module: `rtc_cal_trim`

## Requirements
- R1: With no adjustment active, `sec_tick` pulses for exactly one clock after every TICKS_PER_SEC (32768) oscillator ticks.
- R2: `minute_pos` starts at 0. It advances by one together with the `sec_tick` that ends second SEC_PER_MIN-1 of a minute. It wraps from MIN_PER_CYCLE-1 (63) back to 0 and changes at no other time.
- R3: With `cal_faster`=1 and a step count N>0, the first second (second 0) of each minute whose position is below 2×N lasts TICKS_PER_SEC-INJECT_CNT ticks (32768-256).
- R4: With `cal_faster`=0 and a step count N>0, those same seconds last TICKS_PER_SEC+SUPPRESS_CNT ticks (32768+128).
- R5: A step count of 0 leaves every second at its nominal length, whatever the direction bit says.
- R6: A step count of 31 adjusts minutes 0 to 61. Minutes 62 and 63 are never adjusted, whatever the setting.
- R7: The trim setting is sampled on the first oscillator tick of each 64-minute cycle. A change made mid-cycle leaves the rest of that cycle unchanged and applies in full to the next cycle.
- R8: While `tone_en`=1, `tone_out` toggles once every TONE_HALF (32) raw oscillator ticks, which gives 512 Hz, and the trim setting does not affect this. `tone_out` is 0 from the clock after `tone_en` goes to 0.
- R9: While `rst_n` is low, `sec_tick`, `minute_pos` and `tone_out` are all 0.
- R10: Clock cycles with `osc_tick` low advance nothing. Second lengths count oscillator ticks, not clock cycles, and no `sec_tick` follows a cycle that had no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable, once per oscillator period |
| cal_steps | input | 5 | Trim step count N, 0 to 31 |
| cal_faster | input | 1 | 1: shorten adjusted seconds (clock gains); 0: lengthen them (clock loses) |
| tone_en | input | 1 | Enables the 512 Hz test square wave |
| sec_tick | output | 1 | One-cycle pulse at the end of each trimmed second |
| minute_pos | output | 6 | Position of the current minute within the 64-minute cycle |
| tone_out | output | 1 | 512 Hz test square wave, or 0 when disabled |

## Verification
The assertions check several properties on every cycle:
- `sec_tick` is a single-cycle pulse that only follows an oscillator tick.
- `minute_pos` only steps by one, or wraps, on a seconds pulse.
- The adjust window never reaches the last two minutes of the cycle.
- The latched trim setting changes only right after a cycle-start tick.
- The test output is quiet whenever its enable was low.

The exact length of each adjusted second and the total tick count over a full cycle can only be shown by the bench's scenarios, which run whole cycles under each setting. The same holds for the deferred effect of a mid-cycle write, and for the tone's spacing staying fixed under trim.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int CAL_STEP_W = 5;

  typedef struct packed {
    logic                  faster;
    logic [CAL_STEP_W-1:0] steps;
  } cal_word_t;
endpackage

// File: rtl/cal_sec_div.sv
// Seconds prescaler whose terminal count moves when the current second is
// marked for adjustment.
module cal_sec_div #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int INJECT_CNT    = 256,
  parameter int SUPPRESS_CNT  = 128,
  localparam int DIV_W        = $clog2(TICKS_PER_SEC + SUPPRESS_CNT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic adj_now,
  input  logic adj_faster,
  output logic at_origin,
  output logic sec_wrap,
  output logic sec_tick
);
  localparam logic [DIV_W-1:0] LAST_NOM  = DIV_W'(TICKS_PER_SEC - 1);
  localparam logic [DIV_W-1:0] LAST_FAST = DIV_W'(TICKS_PER_SEC - INJECT_CNT - 1);
  localparam logic [DIV_W-1:0] LAST_SLOW = DIV_W'(TICKS_PER_SEC + SUPPRESS_CNT - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_cnt;

  always_comb begin
    if (!adj_now)       last_cnt = LAST_NOM;
    else if (adj_faster) last_cnt = LAST_FAST;
    else                last_cnt = LAST_SLOW;
  end

  // >= keeps the counter bounded if the terminal ever moves below it
  assign sec_wrap  = osc_tick && (div_q >= last_cnt);
  assign at_origin = (div_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= sec_wrap;
      if (osc_tick) begin
        if (sec_wrap) div_q <= '0;
        else          div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_cycle_track.sv
// Tracks second and minute within the 64-minute trim cycle, latches the
// trim word at cycle start and decides whether the current second is trimmed.
module cal_cycle_track
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  localparam int SEC_W        = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1,
  localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             at_origin,
  input  logic             sec_wrap,
  input  cal_word_t        cal_in,
  output logic [MIN_W-1:0] minute_q,
  output logic             cycle_start,
  output cal_word_t        cal_q,
  output logic             adj_now,
  output logic             adj_faster
);
  localparam int ADJ_LIMIT = MIN_PER_CYCLE - 2;
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

  logic [SEC_W-1:0] sec_q;
  int               span;

  assign cycle_start = osc_tick && at_origin && (sec_q == '0) && (minute_q == '0);

  always_comb begin
    span = 2 * int'(cal_q.steps);
    if (span > ADJ_LIMIT) span = ADJ_LIMIT;
    adj_now = (sec_q == '0) && (int'(minute_q) < span);
  end

  assign adj_faster = cal_q.faster;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q    <= '0;
      minute_q <= '0;
      cal_q    <= '0;
    end else begin
      if (cycle_start) cal_q <= cal_in;
      if (sec_wrap) begin
        if (sec_q == SEC_LAST) begin
          sec_q <= '0;
          if (minute_q == MIN_LAST) minute_q <= '0;
          else                      minute_q <= minute_q + 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_test_tone.sv
// Untrimmed square wave from the raw oscillator tick.
module cal_test_tone #(
  parameter int TONE_HALF = 32,
  localparam int CNT_W    = (TONE_HALF > 1) ? $clog2(TONE_HALF) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic tone_en,
  output logic tone_out
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TONE_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sq_q     <= 1'b0;
      tone_out <= 1'b0;
    end else begin
      tone_out <= tone_en && sq_q;
      if (osc_tick) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q <= '0;
          sq_q  <= !sq_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal_trim.sv
module rtc_cal_trim
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  parameter int INJECT_CNT    = 256,
  parameter int SUPPRESS_CNT  = 128,
  parameter int TONE_HALF     = 32,
  localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  osc_tick,
  input  logic [CAL_STEP_W-1:0] cal_steps,
  input  logic                  cal_faster,
  input  logic                  tone_en,
  output logic                  sec_tick,
  output logic [MIN_W-1:0]      minute_pos,
  output logic                  tone_out
);
  cal_word_t cal_in;
  cal_word_t cal_q;
  logic      at_origin;
  logic      sec_wrap;
  logic      cycle_start;
  logic      adj_now;
  logic      adj_faster;

  assign cal_in.faster = cal_faster;
  assign cal_in.steps  = cal_steps;

  cal_sec_div #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .INJECT_CNT   (INJECT_CNT),
    .SUPPRESS_CNT (SUPPRESS_CNT)
  ) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .adj_now   (adj_now),
    .adj_faster(adj_faster),
    .at_origin (at_origin),
    .sec_wrap  (sec_wrap),
    .sec_tick  (sec_tick)
  );

  cal_cycle_track #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(MIN_PER_CYCLE)
  ) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_tick   (osc_tick),
    .at_origin  (at_origin),
    .sec_wrap   (sec_wrap),
    .cal_in     (cal_in),
    .minute_q   (minute_pos),
    .cycle_start(cycle_start),
    .cal_q      (cal_q),
    .adj_now    (adj_now),
    .adj_faster (adj_faster)
  );

  cal_test_tone #(
    .TONE_HALF(TONE_HALF)
  ) tone_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_tick(osc_tick),
    .tone_en (tone_en),
    .tone_out(tone_out)
  );
endmodule

// File: rtl/rtc_cal_trim_chk.sv
module rtc_cal_trim_chk
  import rtc_cal_pkg::*;
#(
  parameter int MIN_PER_CYCLE = 64,
  parameter int MIN_W         = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             tone_en,
  input logic             sec_tick,
  input logic [MIN_W-1:0] minute_pos,
  input logic             tone_out,
  input logic             cycle_start,
  input cal_word_t        cal_q,
  input logic             adj_now
);
  // R1
  sec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> !sec_tick);

  // R2
  minute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minute_pos != $past(minute_pos)) |->
      (sec_tick && ((minute_pos == $past(minute_pos) + 1'b1) || (minute_pos == '0))));

  // R6
  adj_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_now |-> (int'(minute_pos) < MIN_PER_CYCLE - 2));

  // R7
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q != $past(cal_q)) |-> $past(cycle_start));

  // R8
  tone_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tone_en) |-> !tone_out);
endmodule

bind rtc_cal_trim rtc_cal_trim_chk #(
  .MIN_PER_CYCLE(MIN_PER_CYCLE),
  .MIN_W        (MIN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_tick   (osc_tick),
  .tone_en    (tone_en),
  .sec_tick   (sec_tick),
  .minute_pos (minute_pos),
  .tone_out   (tone_out),
  .cycle_start(cycle_start),
  .cal_q      (cal_q),
  .adj_now    (adj_now)
);

// File: tb/rtc_cal_trim_tb_top.sv
module rtc_cal_trim_tb_top;
  localparam int TPS  = 64;
  localparam int SPM  = 2;
  localparam int MPC  = 64;
  localparam int ADD  = 8;
  localparam int SUB  = 4;
  localparam int HALF = 4;
  localparam int CYC_SECS = MPC * SPM;

  typedef struct packed {
    logic       faster;
    logic [4:0] steps;
    int         adj_secs;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd3,  6},
    '{1'b0, 5'd3,  6},
    '{1'b1, 5'd0,  0},
    '{1'b0, 5'd0,  0},
    '{1'b1, 5'd31, 62},
    '{1'b0, 5'd31, 62},
    '{1'b0, 5'd1,  2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [4:0] cal_steps = '0;
  logic       cal_faster = 1'b0;
  logic       tone_en = 1'b0;
  logic       sec_tick;
  logic [5:0] minute_pos;
  logic       tone_out;

  int checks = 0;
  int fails  = 0;

  // monitor model state
  int m_sec, m_min, m_cnt, len_err, min_err, tot, nsec;
  logic       l_fast;
  logic [4:0] l_steps;
  int tone_cnt, tone_seen, tone_err, tone_hi;
  logic tone_prev;

  always #10 clk = !clk;

  rtc_cal_trim #(
    .TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC),
    .INJECT_CNT(ADD), .SUPPRESS_CNT(SUB), .TONE_HALF(HALF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_steps(cal_steps),
    .cal_faster(cal_faster), .tone_en(tone_en), .sec_tick(sec_tick),
    .minute_pos(minute_pos), .tone_out(tone_out)
  );

  function automatic int exp_len(int s, int mn, logic f, logic [4:0] n);
    int span;
    span = 2 * int'(n);
    if (span > MPC - 2) span = MPC - 2;
    if (s == 0 && mn < span) return f ? TPS - ADD : TPS + SUB;
    return TPS;
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (osc_tick) begin
        m_cnt++;
        tot++;
        tone_cnt++;
      end
      if (tone_out) tone_hi++;
      if (tone_out != tone_prev) begin
        if (tone_seen >= 2 && tone_cnt != HALF) tone_err++;
        tone_seen++;
        tone_cnt = 0;
      end
      tone_prev = tone_out;
      if (sec_tick) begin
        if (m_cnt != exp_len(m_sec, m_min, l_fast, l_steps)) len_err++;
        m_cnt = 0;
        nsec++;
        if (m_sec == SPM - 1) begin
          m_sec = 0;
          m_min = (m_min == MPC - 1) ? 0 : m_min + 1;
        end else begin
          m_sec++;
        end
        if (m_sec == 0 && m_min == 0) begin
          l_fast  = cal_faster;
          l_steps = cal_steps;
        end
        if (int'(minute_pos) != m_min) min_err++;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    m_sec = 0; m_min = 0; m_cnt = 0; len_err = 0; min_err = 0; tot = 0; nsec = 0;
    l_fast = cal_faster; l_steps = cal_steps;
    tone_cnt = 0; tone_seen = 0; tone_err = 0; tone_hi = 0; tone_prev = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    mon_clear();
    rst_n = 1'b1;
  endtask

  task automatic run_secs(int k);
    int target;
    target = nsec + k;
    @(negedge clk);
    osc_tick = 1'b1;
    while (nsec < target) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic run_ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_tick = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        osc_tick = 1'b0;
      end
    end
    @(negedge clk);
    osc_tick = 1'b0;
  endtask

  function automatic string tag_for(logic f, logic [4:0] n);
    if (n == 0) return "R5";
    if (n == 31) return "R6";
    return f ? "R3" : "R4";
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int exp_tot;
    mon_clear();
    // R9: outputs held low during reset, even with ticks and tone enabled
    tone_en = 1'b1;
    osc_tick = 1'b1;
    repeat (5) @(negedge clk);
    check(sec_tick == 1'b0 && tone_out == 1'b0, "R9 reset sec/tone",
          int'({sec_tick, tone_out}), 0);
    check(minute_pos == 6'd0, "R9 reset minute_pos", int'(minute_pos), 0);
    osc_tick = 1'b0;
    tone_en = 1'b0;

    // Table walk: one full cycle per trim setting
    for (int v = 0; v < NVEC; v++) begin
      cal_faster = VECS[v].faster;
      cal_steps  = VECS[v].steps;
      do_reset();
      run_secs(CYC_SECS);
      check(len_err == 0, {"R1,", tag_for(VECS[v].faster, VECS[v].steps), " second lengths"},
            len_err, 0);
      check(min_err == 0, "R2 minute_pos track", min_err, 0);
      exp_tot = CYC_SECS * TPS + VECS[v].adj_secs * (VECS[v].faster ? -ADD : SUB);
      check(tot == exp_tot, {tag_for(VECS[v].faster, VECS[v].steps), " cycle ticks"},
            tot, exp_tot);
    end
    check(minute_pos == 6'd0, "R2 wrap to 0 after cycle", int'(minute_pos), 0);

    // R7: mid-cycle write deferred to next cycle
    cal_faster = 1'b1;
    cal_steps  = 5'd2;
    do_reset();
    run_secs(10 * SPM);
    check(minute_pos == 6'd10, "R2 minute 10 reached", int'(minute_pos), 10);
    cal_steps = 5'd20;
    run_secs(CYC_SECS - 10 * SPM);
    check(len_err == 0, "R7 current cycle unchanged", len_err, 0);
    tot = 0;
    len_err = 0;
    run_secs(CYC_SECS);
    exp_tot = CYC_SECS * TPS - 40 * ADD;
    check(tot == exp_tot, "R7 next cycle uses new setting", tot, exp_tot);
    check(len_err == 0, "R7 next cycle second lengths", len_err, 0);

    // R10: gapped ticks, lengths counted in ticks
    cal_faster = 1'b0;
    cal_steps  = 5'd0;
    do_reset();
    run_ticks(3 * TPS, 2);
    repeat (3) @(negedge clk);
    check(nsec == 3, "R10 seconds from gapped ticks", nsec, 3);
    check(len_err == 0, "R10 tick-counted lengths", len_err, 0);
    run_ticks(TPS - 1, 0);
    repeat (20) @(negedge clk);
    check(nsec == 3, "R10 no second without tick", nsec, 3);

    // R8: tone spacing under strong trim, then quiet when disabled
    cal_faster = 1'b1;
    cal_steps  = 5'd31;
    tone_en    = 1'b1;
    do_reset();
    run_ticks(40 * HALF, 0);
    check(tone_err == 0, "R8 tone half-period", tone_err, 0);
    check(tone_seen >= 35, "R8 tone toggles", tone_seen, 35);
    cal_faster = 1'b0;
    tone_cnt = 0; tone_seen = 0; tone_err = 0;
    run_ticks(40 * HALF, 0);
    check(tone_err == 0, "R8 tone unaffected by trim", tone_err, 0);
    tone_en = 1'b0;
    repeat (2) @(negedge clk);
    tone_hi = 0;
    run_ticks(50, 0);
    check(tone_hi == 0, "R8 tone off when disabled", tone_hi, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule